// File: doc/BRIEF.md
# Coarse Band Calibration Controller

This controller chooses one of eight discrete oscillator tuning bands before the fine frequency loop is allowed to lock. While `enable` is high it runs a repeating measurement cycle made of two equal phases, each timed by a fixed number of ticks from a slow reference. In the first phase the coarse loop is asked to lock to the lower threshold frequency. In the second phase it is asked to lock to the upper threshold frequency. The `target_hi` output selects which of the two targets the coarse loop divider uses.

At the end of each phase the controller latches two comparator flags on the loop-filter voltage. One flag says the voltage is above the high limit. The other says it is below the low limit. After the second phase ends, the four latched results give exactly one verdict. The band moves up one step, moves down one step, or is accepted.

When a band is accepted, `ok` rises and control passes to the main loop. The search stays parked until `enable` drops or a `recal` pulse restarts it. The flags come from analog comparators and are brought into the clock domain through a short synchronizer.

Top module: `coarse_band_cal`

## Requirements
- R1: Reset state: while `rst_n` is low and after it is released, `band` equals START_CODE (default 3'b000), `ok` is 0 and `target_hi` is 0.
- R2: Phase timing. After `enable` is sampled high, `target_hi` stays 0 (lower-threshold phase) for PHASE_TICKS `ref_tick` pulses (default 128). It then stays 1 (upper-threshold phase) for PHASE_TICKS pulses. With a tick every second clock, a full upper phase lasts 256 clocks, and the low interval from the fall of `target_hi` to its next rise also lasts 256 clocks.
- R3: The flags are taken into account only as they stand at the final tick of each phase, after the synchronizer delay. A flag raised in the middle of a phase and dropped before its end has no effect on `band` or on the verdict.
- R4: Step up. If `v_over_hi` was 1 at the end of the lower-threshold phase, `band` increases by one. This happens on the clock edge one cycle after `target_hi` falls.
- R5: Step down. If the step-up condition is absent and `v_under_lo` was 1 at the end of the upper-threshold phase, `band` decreases by one at the same point in the cycle.
- R6: Accept. If neither condition holds, `ok` rises one cycle after `target_hi` falls. `band` then stays fixed and `target_hi` stays 0 for as long as `ok` is 1.
- R7: Priority. When both the step-up and the step-down conditions hold in the same cycle, the band steps up.
- R8: Saturation. A step up at 3'b111 and a step down at 3'b000 leave `band` unchanged, never wrapping, and the search keeps cycling without raising `ok`.
- R9: Convergence. Starting from 3'b000 or from 3'b111, a comparator behaviour that points toward a band B makes the search finish with `band` equal to B and `ok` equal to 1.
- R10: Dropping `enable` clears `ok` and `target_hi` on the next clock edge and keeps `band`. The search stays idle until `enable` returns, and it then restarts with the lower-threshold phase.
- R11: A one-cycle `recal` pulse while enabled clears `ok` on the next clock edge and restarts the search from a fresh lower-threshold phase, starting from the current band.
- R12: `band` changes by exactly one step per update, and only at a verdict, two clocks after the last upper-phase clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per slow reference period (phase timebase) |
| enable | input | 1 | Runs the search while high; idle and `ok` cleared while low |
| recal | input | 1 | One-cycle pulse that restarts the search |
| v_over_hi | input | 1 | Comparator flag: loop-filter voltage above the high limit |
| v_under_lo | input | 1 | Comparator flag: loop-filter voltage below the low limit |
| band | output | BAND_W | Selected oscillator band code |
| target_hi | output | 1 | 0 selects the lower threshold target, 1 the upper one |
| ok | output | 1 | Band accepted; main loop may take over |

## Verification
The properties assume that `ref_tick` and `recal` are single-cycle pulses synchronous to `clk`, and that `enable` is a clean synchronous level. They also assume that the comparator flags are settled for longer than the synchronizer depth before each phase ends. The stimulus produces ticks on every other clock and changes every input only just after a falling clock edge. The flags come from a behavioural model keyed to `band` and `target_hi`. Where flags are forced by hand, they change at least a hundred clocks away from any phase boundary, so a latched value is never ambiguous.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOW    = 3'd1,
    ST_HIGH   = 3'd2,
    ST_DECIDE = 3'd3,
    ST_DONE   = 3'd4
  } cal_state_t;

  typedef enum logic [1:0] {
    STEP_UP   = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_KEEP = 2'd2
  } verdict_t;

  // Four latched comparator results of one measurement cycle
  typedef struct packed {
    logic low_over;   // lower-target phase ended with voltage above high limit
    logic low_under;  // lower-target phase ended with voltage below low limit
    logic high_over;  // upper-target phase ended with voltage above high limit
    logic high_under; // upper-target phase ended with voltage below low limit
  } probe_set_t;

  // Band too slow wins over band too fast
  function automatic verdict_t judge(input probe_set_t p);
    if (p.low_over)        return STEP_UP;
    else if (p.high_under) return STEP_DOWN;
    else                   return STEP_KEEP;
  endfunction

endpackage

// File: rtl/cbc_flag_sync.sv
module cbc_flag_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= din;
          for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign dout = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/cbc_phase_timer.sv
module cbc_phase_timer #(
  parameter int PHASE_TICKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic phase_end
);

  localparam int CW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (tick)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign phase_end = !clear && tick && (cnt == LAST);

endmodule

// File: rtl/cbc_result_store.sv
module cbc_result_store
  import cbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_low,
  input  logic       cap_high,
  input  logic       over,
  input  logic       under,
  output probe_set_t probes
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      probes <= '0;
    end else begin
      if (cap_low) begin
        probes.low_over  <= over;
        probes.low_under <= under;
      end
      if (cap_high) begin
        probes.high_over  <= over;
        probes.high_under <= under;
      end
    end
  end

endmodule

// File: rtl/cbc_band_reg.sv
module cbc_band_reg #(
  parameter int BAND_W     = 3,
  parameter int START_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_up,
  input  logic              step_down,
  output logic [BAND_W-1:0] band
);

  localparam logic [BAND_W-1:0] TOP_CODE  = {BAND_W{1'b1}};
  localparam logic [BAND_W-1:0] BASE_CODE = '0;
  localparam logic [BAND_W-1:0] INIT_CODE = BAND_W'(START_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)                                 band <= INIT_CODE;
    else if (step_up   && band != TOP_CODE)     band <= band + 1'b1;
    else if (step_down && band != BASE_CODE)    band <= band - 1'b1;
  end

endmodule

// File: rtl/coarse_band_cal.sv
module coarse_band_cal
  import cbc_pkg::*;
#(
  parameter int BAND_W      = 3,
  parameter int PHASE_TICKS = 128,
  parameter int START_CODE  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              enable,
  input  logic              recal,
  input  logic              v_over_hi,
  input  logic              v_under_lo,
  output logic [BAND_W-1:0] band,
  output logic              target_hi,
  output logic              ok
);

  cal_state_t state, state_nx;
  logic [1:0] flags_s;
  logic       phase_end, timer_clr, measuring, restart;
  probe_set_t probes;
  verdict_t   verdict;

  cbc_flag_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({v_over_hi, v_under_lo}), .dout(flags_s)
  );

  assign measuring = (state == ST_LOW) || (state == ST_HIGH);
  assign restart   = !enable || (recal && state != ST_IDLE);
  assign timer_clr = !measuring || restart;

  cbc_phase_timer #(.PHASE_TICKS(PHASE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clr),
    .tick(ref_tick), .phase_end(phase_end)
  );

  cbc_result_store u_store (
    .clk(clk), .rst_n(rst_n),
    .cap_low (phase_end && state == ST_LOW),
    .cap_high(phase_end && state == ST_HIGH),
    .over(flags_s[1]), .under(flags_s[0]),
    .probes(probes)
  );

  assign verdict = judge(probes);

  cbc_band_reg #(.BAND_W(BAND_W), .START_CODE(START_CODE)) u_band (
    .clk(clk), .rst_n(rst_n),
    .step_up  (!restart && state == ST_DECIDE && verdict == STEP_UP),
    .step_down(!restart && state == ST_DECIDE && verdict == STEP_DOWN),
    .band(band)
  );

  always_comb begin
    state_nx = state;
    if (!enable) begin
      state_nx = ST_IDLE;
    end else if (recal) begin
      state_nx = ST_LOW;
    end else begin
      case (state)
        ST_IDLE:   state_nx = ST_LOW;
        ST_LOW:    if (phase_end) state_nx = ST_HIGH;
        ST_HIGH:   if (phase_end) state_nx = ST_DECIDE;
        ST_DECIDE: state_nx = (verdict == STEP_KEEP) ? ST_DONE : ST_LOW;
        ST_DONE:   state_nx = ST_DONE;
        default:   state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign target_hi = (state == ST_HIGH);
  assign ok        = (state == ST_DONE);

endmodule

// File: rtl/coarse_band_cal_chk.sv
module coarse_band_cal_chk #(
  parameter int BAND_W      = 3,
  parameter int PHASE_TICKS = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              enable,
  input logic              recal,
  input logic [BAND_W-1:0] band,
  input logic              target_hi,
  input logic              ok
);

  localparam int TW = $clog2(PHASE_TICKS + 1) + 1;
  logic [TW-1:0] hi_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n || !target_hi)   hi_ticks <= '0;
    else if (ref_tick)          hi_ticks <= hi_ticks + 1'b1;
  end

  // R2: the upper phase never outlasts its tick budget
  p_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= TW'(PHASE_TICKS));

  // R12: a band update moves by exactly one code, never wrapping
  p_single_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (band != $past(band)) |->
      (({1'b0, band} == {1'b0, $past(band)} + 1'b1) ||
       ({1'b0, band} + 1'b1 == {1'b0, $past(band)})));

  // R4: band updates only right after the upper phase, outside ok
  p_update_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (band != $past(band)) |-> (!$past(target_hi) && !$past(ok) && $past(target_hi, 2)));

  // R6: accepted band is frozen and target stays low
  p_hold_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(ok)) |-> $stable(band));

  p_ok_low_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> !target_hi);

  // R10: disable clears the handover
  p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ok && !target_hi));

  // R11: a restart pulse clears the handover
  p_recal_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    recal |=> !ok);

endmodule

bind coarse_band_cal coarse_band_cal_chk #(
  .BAND_W(BAND_W), .PHASE_TICKS(PHASE_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .enable(enable),
  .recal(recal), .band(band), .target_hi(target_hi), .ok(ok)
);

// File: tb/coarse_band_cal_bench.sv
module coarse_band_cal_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic enable = 1'b0;
  logic recal = 1'b0;
  logic v_over_hi = 1'b0;
  logic v_under_lo = 1'b0;
  logic [2:0] band;
  logic target_hi;
  logic ok;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  cyc     = 0;
  int  true_band = 0;
  bit  model_on = 1'b1;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  coarse_band_cal u_coarse_band_cal (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .enable(enable),
    .recal(recal), .v_over_hi(v_over_hi), .v_under_lo(v_under_lo),
    .band(band), .target_hi(target_hi), .ok(ok)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // reference ticks every other clock and a behavioural comparator model
  always @(negedge clk) begin
    cyc++;
    ref_tick <= (cyc % 2 == 0);
    if (model_on) begin
      v_over_hi  <= !target_hi && (int'(band) < true_band);
      v_under_lo <=  target_hi && (int'(band) > true_band);
    end
    if (cyc > 190000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_up();
    end
  end

  // phase-length and band-update monitor
  bit prev_thi = 1'b0;
  bit hi_valid = 1'b0, lo_valid = 1'b0, armed = 1'b0;
  int hi_len = 0, lo_len = 0, since_fall = 100;
  logic [2:0] prev_band = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      armed = 1'b0;
    end else begin
      if (!enable || recal || ok) begin hi_valid = 1'b0; lo_valid = 1'b0; end
      if (armed && prev_thi && !target_hi) begin
        if (hi_valid) check(hi_len == 256, "R2", "upper phase clocks", hi_len, 256);
        hi_len = 0; lo_len = 1; since_fall = 1; lo_valid = 1'b1;
      end else if (armed && !prev_thi && target_hi) begin
        if (lo_valid) check(lo_len == 256, "R2", "low interval clocks", lo_len, 256);
        hi_len = 1; hi_valid = 1'b1; lo_valid = 1'b0; since_fall++;
      end else begin
        since_fall++;
        if (target_hi) hi_len++; else lo_len++;
      end
      if (armed && band !== prev_band) begin
        check(since_fall == 2, "R12", "band update point", since_fall, 2);
        check((int'(band) - int'(prev_band) == 1) || (int'(prev_band) - int'(band) == 1),
              "R12", "band step size", int'(band), int'(prev_band));
      end
      prev_thi  = target_hi;
      prev_band = band;
      armed     = 1'b1;
    end
  end

  task automatic wait_ok(input string req, input int exp_band);
    int n = 0;
    while (!ok && n < 12000) begin step(); n++; end
    check(ok === 1'b1, req, "ok reached", int'(ok), 1);
    check(band == 3'(exp_band), req, "final band", int'(band), exp_band);
  endtask

  task automatic wait_band(input int b);
    int n = 0;
    while (band != 3'(b) && n < 12000) begin step(); n++; end
  endtask

  task automatic pulse_recal();
    recal = 1'b1; step(); recal = 1'b0;
  endtask

  task automatic wait_fall();
    bit p = target_hi;
    int n = 0;
    step();
    while (!(p && !target_hi) && n < 3000) begin p = target_hi; step(); n++; end
  endtask

  task automatic t_reset_state();
    check(band == 3'd0, "R1", "band in reset", int'(band), 0);
    check(ok == 1'b0, "R1", "ok in reset", int'(ok), 0);
    rst_n = 1'b1; step();
    check(band == 3'd0, "R1", "band after reset", int'(band), 0);
    check(ok == 1'b0 && target_hi == 1'b0, "R1", "ok/target after reset",
          int'({ok, target_hi}), 0);
  endtask

  task automatic t_search_up();
    true_band = 3; enable = 1'b1;
    wait_ok("R9", 3);
    for (int i = 0; i < 600; i++) step();
    check(ok == 1'b1 && band == 3'd3, "R6", "held after accept", int'(band), 3);
    check(target_hi == 1'b0, "R6", "target while ok", int'(target_hi), 0);
  endtask

  task automatic t_disable();
    bit rose = 1'b0;
    enable = 1'b0; step(); step();
    check(ok == 1'b0, "R10", "ok after disable", int'(ok), 0);
    check(band == 3'd3, "R10", "band kept", int'(band), 3);
    for (int i = 0; i < 600; i++) begin step(); if (target_hi) rose = 1'b1; end
    check(!rose, "R10", "idle while disabled", int'(rose), 0);
    true_band = 5; enable = 1'b1;
    wait_ok("R10", 5);
  endtask

  task automatic t_recal_down();
    true_band = 1; pulse_recal(); step();
    check(ok == 1'b0, "R11", "ok after recal", int'(ok), 0);
    wait_ok("R5", 1);
  endtask

  task automatic t_saturate();
    true_band = 8; pulse_recal();
    wait_band(7);
    for (int i = 0; i < 1600; i++) step();
    check(band == 3'd7, "R8", "held at top", int'(band), 7);
    check(ok == 1'b0, "R8", "no accept at top", int'(ok), 0);
    true_band = -1;
    wait_band(0);
    for (int i = 0; i < 1600; i++) step();
    check(band == 3'd0, "R8", "held at bottom", int'(band), 0);
    check(ok == 1'b0, "R8", "no accept at bottom", int'(ok), 0);
  endtask

  task automatic t_from_top();
    true_band = 8; wait_band(7);
    true_band = 4;
    wait_ok("R9", 4);
  endtask

  task automatic t_priority();
    model_on = 1'b0;
    v_over_hi = 1'b1; v_under_lo = 1'b1;
    pulse_recal();
    wait_fall();
    check(band == 3'd4, "R7", "band before verdict", int'(band), 4);
    step();
    check(band == 3'd5, "R7", "up wins over down", int'(band), 5);
    v_over_hi = 1'b0; v_under_lo = 1'b0;
    wait_ok("R6", 5);
  endtask

  task automatic t_latch_end_only();
    int n = 0;
    v_over_hi = 1'b1; v_under_lo = 1'b0;
    pulse_recal();
    for (int i = 0; i < 100; i++) step();
    v_over_hi = 1'b0;
    while (!target_hi && n < 3000) begin step(); n++; end
    for (int i = 0; i < 100; i++) step();
    v_under_lo = 1'b1;
    for (int i = 0; i < 20; i++) step();
    v_under_lo = 1'b0;
    wait_ok("R3", 5);
    model_on = 1'b1;
  endtask

  initial begin
    step(); step();
    t_reset_state();
    t_search_up();
    t_disable();
    t_recal_down();
    t_saturate();
    t_from_top();
    t_priority();
    t_latch_end_only();
    done = 1'b1;
    finish_up();
  end

endmodule